// File: doc/BRIEF.md
# Serial Unlock Pattern Recognizer

This block sits beside a byte-wide memory and watches its bus cycles to find a hidden doorway into a companion timekeeping device. Software opens the doorway by issuing a run of ordinary memory writes, one key bit per write, carried on data bit 0. The block compares each of these bits against a fixed 64-bit key. When every key bit has matched in an unbroken run of writes, the block raises an unlock flag. The cycles that follow then belong to the timekeeper, and the memory is held off for them.

The bus is reduced to per-cycle strobes. A read-done pulse or a write-done pulse is qualified by chip select, and the data bit is sampled with the write pulse. Writes made while the key is being matched still reach the memory, so the block never blocks them. A read during matching rewinds the matcher to the first key bit. A wrong bit freezes the matcher until the next read. Once unlocked, the block counts a fixed number of qualified accesses and then relocks by itself. An abort input relocks it at once.

Top module: `unlock_seq_top`

## Requirements
- R1: After reset, `unlock` is 0, `mem_disable` is 0 and the matcher waits for key bit 0.
- R2: Key bit i is bit (i mod 8) of key byte i/8. The bytes are C5, 3A, A3, 5C, C5, 3A, A3, 5C in transfer order, so each byte goes least significant bit first. A write whose `dq0` equals the expected bit advances the matcher by one bit.
- R3: `unlock` rises on the clock edge that samples the 64th consecutive matching write, and never earlier.
- R4: A write whose `dq0` differs from the expected bit freezes the matcher. Every later write is ignored until a read, even if those writes carry the correct remaining bits.
- R5: A qualified read while locked returns the matcher to key bit 0 and clears a freeze, which discards any partial match.
- R6: A cycle with `ce` low counts as no access. It neither advances, rewinds nor freezes the matcher, and it does not advance the transfer count.
- R7: While locked, `mem_disable` is 0 for every access, including the key writes.
- R8: While unlocked, `mem_disable` equals `ce`.
- R9: While unlocked, each qualified read or write counts toward the transfer. `unlock` falls on the edge that samples the 64th such access, and the matcher is then back at key bit 0.
- R10: `abort_req` high at a clock edge relocks the block and returns the matcher to key bit 0 with no freeze, whatever the state.
- R11: A cycle with `ce`, `rd_stb` and `wr_stb` all high counts as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip select active for this cycle |
| rd_stb | input | 1 | A read cycle completes this clock |
| wr_stb | input | 1 | A write cycle completes this clock |
| dq0 | input | 1 | Data bit 0 of the write cycle |
| abort_req | input | 1 | Abort the transfer and relock |
| unlock | output | 1 | Timekeeper owns the bus |
| mem_disable | output | 1 | Memory must ignore this cycle |

## Verification
The bench builds the block with its default parameters: a 64-bit key and a 64-access transfer window. At that size a complete unlock, a full window and several relocks take only a few thousand cycles. The runs include the real last key bit, the freeze after a late mismatch and the window's final access. Idle cycles with chip select low are mixed into both the key runs and the transfers. Reads, aborts and simultaneous strobes are placed both at the start and in the middle of a partial match.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

  localparam int unsigned KEY_BITS_DEF = 64;
  localparam logic [KEY_BITS_DEF-1:0] KEY_DEF = 64'h5CA3_3AC5_5CA3_3AC5;
  localparam int unsigned XFER_DEF = 64;

  typedef struct packed {
    logic rd;
    logic wr;
    logic any;
  } access_t;

endpackage

// File: rtl/unlock_access_decode.sv
module unlock_access_decode
  import unlock_seq_pkg::*;
(
  input  logic    ce,
  input  logic    rd_stb,
  input  logic    wr_stb,
  output access_t ev
);

  always_comb begin
    ev.wr  = ce & wr_stb;
    ev.rd  = ce & rd_stb & ~wr_stb;
    ev.any = ev.wr | ev.rd;
  end

endmodule

// File: rtl/unlock_key_matcher.sv
module unlock_key_matcher
  import unlock_seq_pkg::*;
#(
  parameter int unsigned KEY_BITS = KEY_BITS_DEF,
  parameter logic [KEY_BITS-1:0] KEY = KEY_DEF
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    clear,
  input  access_t ev,
  input  logic    dq0,
  output logic    full_o
);

  localparam int unsigned PTR_W = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_BITS - 1);

  function automatic logic expected_bit(input logic [PTR_W-1:0] p);
    return KEY[p];
  endfunction

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0] ptr;
  logic             frozen;
  logic             take, hit, miss, rewind;

  assign take   = en & ev.wr & ~frozen;
  assign hit    = take & (dq0 == expected_bit(ptr));
  assign miss   = take & (dq0 != expected_bit(ptr));
  assign rewind = en & ev.rd;
  assign full_o = hit & (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      frozen <= 1'b0;
    end else if (clear || rewind) begin
      ptr    <= '0;
      frozen <= 1'b0;
    end else if (hit) begin
      ptr    <= step_ptr(ptr);
    end else if (miss) begin
      frozen <= 1'b1;
    end
  end

  p_read_rewinds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (ptr == '0) && !frozen);
  p_frozen_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !clear && !rewind |=> frozen && $stable(ptr));
  p_idle_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.any && !clear |=> $stable(ptr) && $stable(frozen));
  p_full_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> ptr == '0);

endmodule

// File: rtl/unlock_xfer_window.sv
module unlock_xfer_window
  import unlock_seq_pkg::*;
#(
  parameter int unsigned XFER_CYCLES = XFER_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic acc,
  input  logic abort,
  output logic open_o,
  output logic relock_o
);

  localparam int unsigned CNT_W = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(XFER_CYCLES - 1);

  function automatic logic window_end(input logic [CNT_W-1:0] c);
    return c == LAST;
  endfunction

  logic [CNT_W-1:0] cnt;

  assign relock_o = open_o & acc & window_end(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      open_o <= 1'b0;
      cnt    <= '0;
    end else if (!open_o) begin
      if (start) begin
        open_o <= 1'b1;
        cnt    <= '0;
      end
    end else if (acc) begin
      if (window_end(cnt)) begin
        open_o <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt    <= cnt + 1'b1;
      end
    end
  end

  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  p_closes_after_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    relock_o |=> !open_o);
  p_abort_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !open_o && cnt == '0);

endmodule

// File: rtl/unlock_seq_top.sv
module unlock_seq_top
  import unlock_seq_pkg::*;
#(
  parameter int unsigned KEY_BITS = KEY_BITS_DEF,
  parameter logic [KEY_BITS-1:0] KEY = KEY_DEF,
  parameter int unsigned XFER_CYCLES = XFER_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic dq0,
  input  logic abort_req,
  output logic unlock,
  output logic mem_disable
);

  access_t ev;
  logic    key_full;
  logic    win_open;
  logic    win_relock;

  unlock_access_decode u_dec (
    .ce     (ce),
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .ev     (ev)
  );

  unlock_key_matcher #(
    .KEY_BITS (KEY_BITS),
    .KEY      (KEY)
  ) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (~win_open),
    .clear  (abort_req | win_relock),
    .ev     (ev),
    .dq0    (dq0),
    .full_o (key_full)
  );

  unlock_xfer_window #(
    .XFER_CYCLES (XFER_CYCLES)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (key_full),
    .acc      (ev.any),
    .abort    (abort_req),
    .open_o   (win_open),
    .relock_o (win_relock)
  );

  assign unlock      = win_open;
  assign mem_disable = win_open & ce;

  p_memdis_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |-> !mem_disable);
  p_open_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock) |-> $past(key_full));
  p_single_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev.rd, ev.wr}));
  p_idle_keeps_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ce && !abort_req |=> $stable(unlock));

endmodule

// File: tb/unlock_seq_top_test.sv
`timescale 1ns/1ps
module unlock_seq_top_test;

  logic clk = 1'b0;
  logic rst_n, ce, rd_stb, wr_stb, dq0, abort_req;
  logic unlock, mem_disable;

  always #4 clk = ~clk;

  unlock_seq_top uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .dq0(dq0), .abort_req(abort_req), .unlock(unlock), .mem_disable(mem_disable)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  byte unsigned key_bytes [8] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C, 8'hC5, 8'h3A, 8'hA3, 8'h5C};
  function automatic bit kb(int i);
    return key_bytes[i / 8][i % 8];
  endfunction

  // behavioural reference model
  int m_ptr = 0;
  bit m_frz = 0;
  bit m_unl = 0;
  int m_cnt = 0;

  task automatic model(bit c, bit r, bit w, bit d, bit a);
    bit we = c && w;
    bit re = c && r && !w;
    if (a) begin
      m_unl = 0; m_cnt = 0; m_ptr = 0; m_frz = 0;
    end else if (m_unl) begin
      if (we || re) begin
        if (m_cnt == 63) begin
          m_unl = 0; m_cnt = 0; m_ptr = 0; m_frz = 0;
        end else m_cnt++;
      end
    end else if (re) begin
      m_ptr = 0; m_frz = 0;
    end else if (we && !m_frz) begin
      if (d == kb(m_ptr)) begin
        if (m_ptr == 63) begin m_unl = 1; m_cnt = 0; m_ptr = 0; end
        else m_ptr++;
      end else m_frz = 1;
    end
  endtask

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic step(string tag, bit c, bit r, bit w, bit d, bit a);
    ce = c; rd_stb = r; wr_stb = w; dq0 = d; abort_req = a;
    #1;
    if (m_unl) check("R8 mem_disable", mem_disable, c);
    else       check("R7 mem_disable", mem_disable, 1'b0);
    @(posedge clk);
    model(c, r, w, d, a);
    @(negedge clk);
    check(tag, unlock, m_unl);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, i[0], ~i[0], i[1], 0);
  endtask

  // send key bits [from..upto]; bad >= 0 inverts that bit; both drives rd and wr
  task automatic send_key(string tag, int from, int upto, int bad, bit both);
    for (int i = from; i <= upto; i++) begin
      if (i % 7 == 3) step("R6 idle inside key", 0, 1, 1, ~kb(i), 0);
      step(tag, 1, both, 1, (i == bad) ? ~kb(i) : kb(i), 0);
    end
  endtask

  task automatic xfer(string tag, int n);
    for (int i = 0; i < n; i++) begin
      if (i % 5 == 2) step("R6 idle in window", 0, 1, 0, 0, 0);
      step(tag, 1, i[0], ~i[0], i[1], 0);
    end
  endtask

  initial begin
    rst_n = 0; ce = 1; rd_stb = 0; wr_stb = 0; dq0 = 0; abort_req = 0;
    repeat (3) @(negedge clk);
    check("R1 unlock reset", unlock, 1'b0);
    check("R1 mem_disable reset", mem_disable, 1'b0);
    rst_n = 1;
    idle("R6 idle", 4);

    // R2/R3: full key with idle gaps
    step("R5 initial read", 1, 1, 0, 0, 0);
    send_key("R2 key bits", 0, 62, -1, 0);
    check("R3 not before last bit", unlock, 1'b0);
    send_key("R3 last bit", 63, 63, -1, 0);
    check("R3 unlocked", unlock, 1'b1);

    // R8/R9: window of 64 accesses
    xfer("R9 window", 63);
    check("R9 still open", unlock, 1'b1);
    xfer("R9 window end", 1);
    check("R9 relocked", unlock, 1'b0);
    // pointer back at 0: full key unlocks directly
    send_key("R9 rekey", 0, 63, -1, 0);
    check("R9 rekey unlocks", unlock, 1'b1);
    step("R10 abort open", 0, 0, 0, 0, 1);
    check("R10 abort relocks", unlock, 1'b0);

    // R5: partial match then read rewinds
    send_key("R5 partial", 0, 19, -1, 0);
    step("R5 read", 1, 1, 0, 0, 0);
    send_key("R5 restart", 0, 63, -1, 0);
    check("R5 unlock after rewind", unlock, 1'b1);
    step("R10 abort", 1, 0, 1, 0, 1);

    // R4: mismatch freezes
    send_key("R4 mismatch run", 0, 63, 10, 0);
    check("R4 frozen no unlock", unlock, 1'b0);
    send_key("R4 ignored", 0, 63, -1, 0);
    check("R4 still frozen", unlock, 1'b0);
    step("R4 read clears", 1, 1, 0, 0, 0);
    send_key("R4 after read", 0, 63, -1, 0);
    check("R4 unlock after read", unlock, 1'b1);

    // R10: abort mid-window and mid-match
    xfer("R10 partial window", 20);
    step("R10 abort mid window", 0, 0, 0, 0, 1);
    check("R10 locked", unlock, 1'b0);
    send_key("R10 partial key", 0, 30, -1, 0);
    step("R10 abort mid key", 0, 0, 0, 0, 1);
    send_key("R10 key from 0", 0, 63, -1, 0);
    check("R10 unlock after abort", unlock, 1'b1);
    step("R10 abort", 0, 0, 0, 0, 1);

    // R11: both strobes count as writes
    step("R5 read", 1, 1, 0, 0, 0);
    send_key("R11 both strobes", 0, 63, -1, 1);
    check("R11 unlock", unlock, 1'b1);
    xfer("R9 final window", 64);
    check("R9 final relock", unlock, 1'b0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule